// File: doc/BRIEF.md
# Multi-Buffer DMA Channel Reload Controller

This block sequences one DMA channel through a transfer made of several equal-length buffers. When software enables the channel (with the controller-wide enable already set), the block captures the programmed source start, destination start and buffer length. It then issues one address beat per clock toward a simple memory port. Each beat advances both addresses by the beat width.

When the last beat of a buffer goes out, the block raises a sticky buffer-complete flag. The source address goes back to its captured start, and the destination address keeps counting from where it stopped. The automatic-mode bit and the buffer-complete interrupt mask are sampled only at that moment, and they decide among three outcomes:
- The channel finishes: a chained-complete flag is set and the enable clears itself.
- The channel parks in a stall until software writes the keep strobe.
- The next buffer starts on the very next cycle.

There are three states:
- `ST_IDLE`: channel disabled.
- `ST_RUN`: one beat per cycle.
- `ST_STALL`: waiting for keep.

The transitions are:
- `ST_IDLE`→`ST_RUN`: start, which needs enable and global enable.
- `ST_RUN`→`ST_IDLE`: the last buffer finished with auto off, or a disable.
- `ST_RUN`→`ST_STALL`: a buffer finished with auto on and the interrupt unmasked.
- `ST_RUN`→`ST_RUN`: a buffer finished with auto on and the interrupt masked.
- `ST_STALL`→`ST_RUN`: keep.
- `ST_STALL`→`ST_IDLE`: disable.

Top module: `dma_mbuf_chan`

## Requirements
- R1: After reset the channel is disabled, not stalled, both flags are 0 and `mem_valid` is 0.
- R2: A pulse on `ch_en_set` starts the channel only when `glb_en` is 1 and the channel is idle; otherwise it has no effect.
- R3: While running, the block issues one beat per cycle with `mem_valid`=1. Both addresses step by `BEAT_BYTES` (default 4) per beat. A buffer is `buf_len` beats long, and a length of 0 acts as 1.
- R4: The beat after a buffer boundary uses the source start address captured at enable.
- R5: The destination address continues contiguously across buffer boundaries, including across a stall.
- R6: Every completed buffer sets `btc_flag`, which stays set until `irq_clr`.
- R7: If `auto_mode` is 0 when a buffer completes, `cbtc_flag` is set and `ch_enabled` falls in the same cycle.
- R8: If `auto_mode` is 1 and `btc_unmask` is 1 when a buffer completes, `stalled` goes to 1 and no beat is issued until a `keep_wr` pulse. The first beat follows the cycle after that pulse.
- R9: If `auto_mode` is 1 and `btc_unmask` is 0 when a buffer completes, the next buffer's first beat follows on the next cycle with no gap.
- R10: A `keep_wr` pulse while not stalled has no effect on beats, addresses or status.
- R11: A `ch_en_clr` pulse in a beat cycle lets that beat be the last one. The channel returns to idle, any stall clears, and no completion flag is set by that beat.
- R12: `irq_clr` clears both flags. A flag set in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Controller-wide enable level |
| ch_en_set | input | 1 | Channel enable write pulse |
| ch_en_clr | input | 1 | Channel disable write pulse |
| keep_wr | input | 1 | Resume-from-stall write pulse |
| auto_mode | input | 1 | Automatic multi-buffer mode level |
| btc_unmask | input | 1 | 1 = buffer-complete interrupt unmasked |
| irq_clr | input | 1 | Clear pulse for both flags |
| src_start | input | AW | Programmed source start address |
| dst_start | input | AW | Programmed destination start address |
| buf_len | input | LW | Buffer length in beats |
| ch_enabled | output | 1 | Channel enable status |
| stalled | output | 1 | Stall status |
| btc_flag | output | 1 | Sticky buffer-complete flag |
| cbtc_flag | output | 1 | Sticky chained-complete flag |
| mem_valid | output | 1 | Beat valid toward memory port |
| mem_src_addr | output | AW | Source address of current beat |
| mem_dst_addr | output | AW | Destination address of current beat |

## Verification
The hardest situation to reach is a multi-buffer run whose final buffer is picked out by clearing automatic mode partway through it. This has to happen after a stall has been resumed or after a masked boundary has gone straight into the next buffer.

The directed tasks get there by driving `auto_mode` low at a chosen beat inside the second buffer, counted from the resume or from the boundary. They then check that the destination address has run on across the boundary and that the chained flag appears only at the end of that buffer. Two further tasks cover disables timed exactly on a beat and on a stall.

// File: rtl/dma_mbuf_pkg.sv
package dma_mbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dma_mbuf_fsm.sv
module dma_mbuf_fsm
    import dma_mbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glb_en,
    input  logic        ch_en_set,
    input  logic        ch_en_clr,
    input  logic        keep_wr,
    input  logic        auto_mode,
    input  logic        btc_unmask,
    input  logic        last_beat,
    output chan_state_e state,
    output logic        start,
    output logic        beat,
    output logic        buf_done,
    output logic        chain_done
);
    chan_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ch_en_set && glb_en && !ch_en_clr) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ch_en_clr)           state_d = ST_IDLE;
                else if (last_beat) begin
                    if (!auto_mode)      state_d = ST_IDLE;
                    else if (btc_unmask) state_d = ST_STALL;
                    else                 state_d = ST_RUN;
                end
            end
            ST_STALL: begin
                if (ch_en_clr)    state_d = ST_IDLE;
                else if (keep_wr) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state      = state_q;
        start      = (state_q == ST_IDLE) && ch_en_set && glb_en && !ch_en_clr;
        beat       = (state_q == ST_RUN);
        buf_done   = beat && last_beat && !ch_en_clr;
        chain_done = buf_done && !auto_mode;
    end

    a_r8_stall_needs_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && !keep_wr && !ch_en_clr) |=> (state_q == ST_STALL));
    a_r11_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en_clr |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dma_mbuf_beatcnt.sv
module dma_mbuf_beatcnt #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          beat,
    input  logic [LW-1:0] buf_len,
    output logic          last_beat
);
    localparam int CW = LW + 1;

    logic [LW-1:0] len_q;
    logic [LW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc   = {1'b0, cnt_q} + CW'(1);
    assign last_beat = (cnt_inc >= {1'b0, len_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            len_q <= buf_len;
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= last_beat ? '0 : cnt_inc[LW-1:0];
        end
    end
endmodule

// File: rtl/dma_mbuf_addr.sv
module dma_mbuf_addr #(
    parameter int AW     = 32,
    parameter int STEP   = 4,
    parameter bit RELOAD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          beat,
    input  logic          buf_done,
    input  logic [AW-1:0] start_val,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_next;

    assign addr_next = addr_q + AW'(STEP);
    assign addr      = addr_q;

    generate
        if (RELOAD) begin : g_reload
            logic [AW-1:0] base_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q <= '0;
                    addr_q <= '0;
                end else if (start) begin
                    base_q <= start_val;
                    addr_q <= start_val;
                end else if (beat) begin
                    addr_q <= buf_done ? base_q : addr_next;
                end
            end
            a_r4_src_reload: assert property (@(posedge clk) disable iff (!rst_n)
                buf_done |=> (addr_q == base_q));
        end else begin : g_continue
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     addr_q <= '0;
                else if (start) addr_q <= start_val;
                else if (beat)  addr_q <= addr_next;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_mbuf_irq.sv
module dma_mbuf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_done,
    input  logic chain_done,
    input  logic irq_clr,
    output logic btc_flag,
    output logic cbtc_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btc_flag  <= 1'b0;
            cbtc_flag <= 1'b0;
        end else begin
            if (buf_done)     btc_flag <= 1'b1;
            else if (irq_clr) btc_flag <= 1'b0;
            if (chain_done)   cbtc_flag <= 1'b1;
            else if (irq_clr) cbtc_flag <= 1'b0;
        end
    end

    a_r6_btc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (btc_flag && !irq_clr) |=> btc_flag);
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done && irq_clr) |=> btc_flag);
endmodule

// File: rtl/dma_mbuf_chan.sv
module dma_mbuf_chan
    import dma_mbuf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glb_en,
    input  logic          ch_en_set,
    input  logic          ch_en_clr,
    input  logic          keep_wr,
    input  logic          auto_mode,
    input  logic          btc_unmask,
    input  logic          irq_clr,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic [LW-1:0] buf_len,
    output logic          ch_enabled,
    output logic          stalled,
    output logic          btc_flag,
    output logic          cbtc_flag,
    output logic          mem_valid,
    output logic [AW-1:0] mem_src_addr,
    output logic [AW-1:0] mem_dst_addr
);
    chan_state_e state;
    logic start, beat, buf_done, chain_done, last_beat;

    dma_mbuf_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en_set(ch_en_set),
        .ch_en_clr(ch_en_clr), .keep_wr(keep_wr), .auto_mode(auto_mode),
        .btc_unmask(btc_unmask), .last_beat(last_beat), .state(state),
        .start(start), .beat(beat), .buf_done(buf_done), .chain_done(chain_done)
    );

    dma_mbuf_beatcnt #(.LW(LW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .beat(beat),
        .buf_len(buf_len), .last_beat(last_beat)
    );

    dma_mbuf_addr #(.AW(AW), .STEP(BEAT_BYTES), .RELOAD(1'b1)) u_src (
        .clk(clk), .rst_n(rst_n), .start(start), .beat(beat),
        .buf_done(buf_done), .start_val(src_start), .addr(mem_src_addr)
    );

    dma_mbuf_addr #(.AW(AW), .STEP(BEAT_BYTES), .RELOAD(1'b0)) u_dst (
        .clk(clk), .rst_n(rst_n), .start(start), .beat(beat),
        .buf_done(buf_done), .start_val(dst_start), .addr(mem_dst_addr)
    );

    dma_mbuf_irq u_irq (
        .clk(clk), .rst_n(rst_n), .buf_done(buf_done), .chain_done(chain_done),
        .irq_clr(irq_clr), .btc_flag(btc_flag), .cbtc_flag(cbtc_flag)
    );

    always_comb begin
        ch_enabled = (state != ST_IDLE);
        stalled    = (state == ST_STALL);
        mem_valid  = (state == ST_RUN);
    end

    a_r1_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_enabled) |-> $past(glb_en && ch_en_set));
    a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !mem_valid);
    a_r5_dst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && $past(mem_valid)) |-> (mem_dst_addr == $past(mem_dst_addr) + AW'(BEAT_BYTES)));
    a_r7_chain_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cbtc_flag) |-> !ch_enabled);
endmodule

// File: tb/dma_mbuf_chan_bench.sv
module dma_mbuf_chan_bench;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glb_en = 0, ch_en_set = 0, ch_en_clr = 0, keep_wr = 0;
    logic auto_mode = 0, btc_unmask = 0, irq_clr = 0;
    logic [AW-1:0] src_start = 32'h0000_1000;
    logic [AW-1:0] dst_start = 32'h0000_8000;
    logic [LW-1:0] buf_len = 16'd3;
    logic ch_enabled, stalled, btc_flag, cbtc_flag, mem_valid;
    logic [AW-1:0] mem_src_addr, mem_dst_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_mbuf_chan u_dma_mbuf_chan (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en_set(ch_en_set),
        .ch_en_clr(ch_en_clr), .keep_wr(keep_wr), .auto_mode(auto_mode),
        .btc_unmask(btc_unmask), .irq_clr(irq_clr), .src_start(src_start),
        .dst_start(dst_start), .buf_len(buf_len), .ch_enabled(ch_enabled),
        .stalled(stalled), .btc_flag(btc_flag), .cbtc_flag(cbtc_flag),
        .mem_valid(mem_valid), .mem_src_addr(mem_src_addr), .mem_dst_addr(mem_dst_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_en();
        ch_en_set = 1'b1;
        @(negedge clk);
        ch_en_set = 1'b0;
    endtask

    task automatic clear_flags();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Checks n beats starting at the current negedge; returns on the negedge after the last beat.
    task automatic expect_beats(input int n, input logic [AW-1:0] s0, input logic [AW-1:0] d0);
        for (int i = 0; i < n; i++) begin
            chk("R3 valid", mem_valid, 1);
            chk("R4 src addr", mem_src_addr, s0 + 32'(4 * i));
            chk("R5 dst addr", mem_dst_addr, d0 + 32'(4 * i));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 enabled", ch_enabled, 0);
        chk("R1 stalled", stalled, 0);
        chk("R1 btc", btc_flag, 0);
        chk("R1 cbtc", cbtc_flag, 0);
        chk("R1 valid", mem_valid, 0);
    endtask

    task automatic t_global_gate();
        glb_en = 1'b0;
        pulse_en();
        chk("R2 no start without global", ch_enabled, 0);
        chk("R2 no beat", mem_valid, 0);
        glb_en = 1'b1;
    endtask

    task automatic t_single_buffer();
        auto_mode = 1'b0;
        buf_len = 16'd3;
        pulse_en();
        expect_beats(3, src_start, dst_start);
        chk("R7 enable cleared", ch_enabled, 0);
        chk("R7 cbtc set", cbtc_flag, 1);
        chk("R6 btc set", btc_flag, 1);
        chk("R3 no beat after end", mem_valid, 0);
        repeat (2) @(negedge clk);
        chk("R6 btc sticky", btc_flag, 1);
        clear_flags();
        chk("R12 btc cleared", btc_flag, 0);
        chk("R12 cbtc cleared", cbtc_flag, 0);
    endtask

    task automatic t_stall_resume();
        auto_mode = 1'b1;
        btc_unmask = 1'b1;
        buf_len = 16'd3;
        pulse_en();
        expect_beats(3, src_start, dst_start);
        chk("R8 stalled", stalled, 1);
        chk("R8 no beat", mem_valid, 0);
        chk("R6 btc", btc_flag, 1);
        chk("R8 still enabled", ch_enabled, 1);
        repeat (3) @(negedge clk);
        chk("R8 stall held", stalled, 1);
        chk("R8 stall quiet", mem_valid, 0);
        keep_wr = 1'b1;
        @(negedge clk);
        keep_wr = 1'b0;
        chk("R8 resumed", stalled, 0);
        expect_beats(1, src_start, dst_start + 32'd12);
        auto_mode = 1'b0;
        expect_beats(2, src_start + 32'd4, dst_start + 32'd16);
        chk("R7 final enable clear", ch_enabled, 0);
        chk("R7 final cbtc", cbtc_flag, 1);
        chk("R11 no stall at end", stalled, 0);
        clear_flags();
    endtask

    task automatic t_masked_chain();
        auto_mode = 1'b1;
        btc_unmask = 1'b0;
        buf_len = 16'd2;
        pulse_en();
        expect_beats(2, src_start, dst_start);
        chk("R9 no stall", stalled, 0);
        expect_beats(1, src_start, dst_start + 32'd8);
        auto_mode = 1'b0;
        expect_beats(1, src_start + 32'd4, dst_start + 32'd12);
        chk("R9 chain done", cbtc_flag, 1);
        chk("R9 enable clear", ch_enabled, 0);
        clear_flags();
    endtask

    task automatic t_keep_ignored();
        keep_wr = 1'b1;
        @(negedge clk);
        keep_wr = 1'b0;
        chk("R10 idle keep no start", ch_enabled, 0);
        chk("R10 idle keep no beat", mem_valid, 0);
        auto_mode = 1'b0;
        buf_len = 16'd4;
        pulse_en();
        expect_beats(1, src_start, dst_start);
        keep_wr = 1'b1;
        expect_beats(1, src_start + 32'd4, dst_start + 32'd4);
        keep_wr = 1'b0;
        expect_beats(2, src_start + 32'd8, dst_start + 32'd8);
        chk("R10 normal end", cbtc_flag, 1);
        chk("R10 btc unaffected", btc_flag, 1);
        clear_flags();
    endtask

    task automatic t_disable();
        auto_mode = 1'b1;
        btc_unmask = 1'b1;
        buf_len = 16'd8;
        pulse_en();
        expect_beats(3, src_start, dst_start);
        chk("R11 beat before disable", mem_valid, 1);
        ch_en_clr = 1'b1;
        @(negedge clk);
        ch_en_clr = 1'b0;
        chk("R11 idle", ch_enabled, 0);
        chk("R11 no further beat", mem_valid, 0);
        chk("R11 no btc", btc_flag, 0);
        buf_len = 16'd2;
        pulse_en();
        expect_beats(2, src_start, dst_start);
        chk("R11 stalled before disable", stalled, 1);
        ch_en_clr = 1'b1;
        @(negedge clk);
        ch_en_clr = 1'b0;
        chk("R11 stall cleared", stalled, 0);
        chk("R11 enable cleared", ch_enabled, 0);
        clear_flags();
    endtask

    task automatic t_zero_len_and_clear_race();
        auto_mode = 1'b0;
        buf_len = 16'd0;
        pulse_en();
        irq_clr = 1'b1;
        expect_beats(1, src_start, dst_start);
        irq_clr = 1'b0;
        chk("R3 zero length one beat", ch_enabled, 0);
        chk("R12 set wins over clear", btc_flag, 1);
        clear_flags();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_gate();
        t_single_buffer();
        t_stall_resume();
        t_masked_chain();
        t_keep_ignored();
        t_disable();
        t_zero_len_and_clear_race();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule